// File: doc/BRIEF.md
# Page Program Sequencer

This block gathers the data bytes of one page write and, once the host ends the transaction, runs a timed internal program cycle that commits them to a word-organised storage array. The serial front end gives it three things. First, a start strobe with the starting byte address. Second, one strobe per completed data byte. Third, a commit strobe on the chip-select rising edge. With the commit strobe come two qualifiers: an allow level from the protection logic, and a flag that says a partial byte was in flight when chip select rose.

The array stores 4-byte words, and each word carries 6 Hamming check bits. Because of this, every loaded byte forces its whole word to be rewritten. During the program cycle the block visits the words of the page in ascending order. For each word that holds at least one loaded byte, it reads the stored word and corrects a single flipped data bit. It then merges the loaded bytes over the stored ones, regenerates the check bits and writes the word back. The busy flag stays high for a fixed number of clock ticks. When busy drops, the block pulses a request that clears the write-enable latch.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, busy and welClr are 0 and neither memRd nor memWe is asserted.
- R2: The first data byte after a start strobe goes to the start address's offset within its page (the low log2(PAGE_BYTES) address bits). Each further byte goes to the next offset. After the last offset the next byte lands at offset 0 of the same page, and a later byte replaces an earlier one at the same offset.
- R3: A program cycle starts on a commit strobe only if four conditions hold: a start strobe came since the previous commit strobe, at least one byte was loaded, allow is 1 and bitResidue is 0. Any other commit strobe changes nothing and clears the pending transaction.
- R4: busy rises in the cycle after an accepted commit strobe and stays 1 for exactly PROG_TICKS cycles.
- R5: For each word holding at least one loaded byte, the block issues one read and then, in the next cycle, one write to the same word address. Words with no loaded byte are not accessed, and no array access happens while busy is 0.
- R6: memWordAddr is {page number, word index}, and words are visited in ascending index order. Byte offset 4w+b maps to word w, bits [8b+7:8b].
- R7: In a written word, bytes that were loaded take the loaded value and the other bytes keep the stored value.
- R8: The check bits sit in bits [37:32] of an array word. Check bit k is the XOR of every data bit j whose position code has bit k set. The position code of data bit j is the (j+1)-th integer, counting up from 3, that is not a power of two.
- R9: If the stored data bits differ from what the stored check bits describe by a single data bit, that bit is corrected before the merge.
- R10: While busy is 1, the start, byte and commit strobes are ignored.
- R11: welClr is a single-cycle pulse in the first cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Opens a write transaction at startAddr |
| startAddr | input | ADDR_W | Starting byte address |
| byteValid | input | 1 | One complete data byte is on byteData |
| byteData | input | 8 | Data byte |
| csRise | input | 1 | Commit strobe from the chip-select rising edge |
| bitResidue | input | 1 | A partial byte was received when chip select rose |
| allow | input | 1 | Protection logic permits this write |
| busy | output | 1 | Internal program cycle running (ready bit) |
| welClr | output | 1 | Pulse that clears the write-enable latch |
| memRd | output | 1 | Array word read request (data returns next cycle) |
| memWe | output | 1 | Array word write |
| memWordAddr | output | ADDR_W-2 | Array word address |
| memWrWord | output | 38 | Check bits and data written |
| memRdWord | input | 38 | Check bits and data read |

## Verification
The bench first loads past the end of a page. A design that carried into the next page, or that did not overwrite offsets it had already filled, would write the wrong word addresses or stale bytes. It then commits empty, refused and partial-byte transactions; a design that started a program cycle anyway would raise busy and issue writes the scoreboard never expected. Strobes arrive while busy is high, followed by a commit with no new start; a design that latched them would begin a second cycle. Finally, a single-byte write lands in a word whose stored data has one flipped bit. A design that skipped correction would write the flipped bit back, and one with the wrong check-bit layout would produce a word that does not match.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam int WORD_BYTES = 4;
  localparam int DATA_W = 8 * WORD_BYTES;
  localparam int ECC_W = 6;
  localparam int CODE_W = DATA_W + ECC_W;

  typedef struct packed {
    logic startLoad;
    logic byteStore;
    logic wordReset;
    logic wordAdvance;
  } pwsStrobe_t;

  // Hamming position code of data bit j: skip 1, 2 and all powers of two.
  function automatic logic [ECC_W-1:0] posCode(input int j);
    logic [ECC_W-1:0] r;
    int seen;
    r = '0;
    seen = 0;
    for (int p = 3; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (seen == j) r = ECC_W'(p);
        seen++;
      end
    end
    return r;
  endfunction

  function automatic logic [ECC_W-1:0] eccGen(input logic [DATA_W-1:0] d);
    logic [ECC_W-1:0] e;
    logic [ECC_W-1:0] pc;
    e = '0;
    for (int j = 0; j < DATA_W; j++) begin
      pc = posCode(j);
      for (int k = 0; k < ECC_W; k++) begin
        if (pc[k]) e[k] = e[k] ^ d[j];
      end
    end
    return e;
  endfunction

  function automatic logic [DATA_W-1:0] fixData(input logic [DATA_W-1:0] d,
                                                input logic [ECC_W-1:0] e);
    logic [ECC_W-1:0] syn;
    logic [DATA_W-1:0] r;
    syn = e ^ eccGen(d);
    r = d;
    for (int j = 0; j < DATA_W; j++) begin
      if (syn != '0 && posCode(j) == syn) r[j] = ~d[j];
    end
    return r;
  endfunction
endpackage

// File: rtl/pws_datapath.sv
module pws_datapath
  import pws_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pwsStrobe_t            st,
  input  logic [ADDR_W-1:0]     startAddr,
  input  logic [7:0]            byteData,
  input  logic [CODE_W-1:0]     memRdWord,
  output logic                  anyValid,
  output logic                  wordHasValid,
  output logic                  lastWord,
  output logic [ADDR_W-3:0]     memWordAddr,
  output logic [CODE_W-1:0]     memWrWord
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int WORDS = PAGE_BYTES / WORD_BYTES;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int LANE_W = $clog2(WORD_BYTES);

  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [PAGE_W-1:0]     pageNum;
  logic [OFF_W-1:0]      offset;
  logic [WIDX_W-1:0]     wordIdx;

  // Byte buffer holds data only; its validity lives in validMask.
  always_ff @(posedge clk) begin
    if (st.byteStore) pageBuf[offset] <= byteData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validMask <= '0;
      pageNum   <= '0;
      offset    <= '0;
    end else if (st.startLoad) begin
      validMask <= '0;
      pageNum   <= startAddr[ADDR_W-1:OFF_W];
      offset    <= startAddr[OFF_W-1:0];
    end else if (st.byteStore) begin
      validMask[offset] <= 1'b1;
      offset            <= offset + 1'b1;  // wraps inside the page
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               wordIdx <= '0;
    else if (st.wordReset)   wordIdx <= '0;
    else if (st.wordAdvance) wordIdx <= wordIdx + 1'b1;
  end

  assign anyValid     = |validMask;
  assign wordHasValid = |validMask[{wordIdx, {LANE_W{1'b0}}} +: WORD_BYTES];
  assign lastWord     = (wordIdx == WIDX_W'(WORDS - 1));
  assign memWordAddr  = {pageNum, wordIdx};

  logic [DATA_W-1:0] fixedData;
  logic [DATA_W-1:0] mergedData;

  always_comb begin
    logic [OFF_W-1:0] laneOff;
    fixedData = fixData(memRdWord[DATA_W-1:0], memRdWord[CODE_W-1:DATA_W]);
    mergedData = fixedData;
    for (int b = 0; b < WORD_BYTES; b++) begin
      laneOff = {wordIdx, LANE_W'(b)};
      if (validMask[laneOff]) mergedData[8*b +: 8] = pageBuf[laneOff];
    end
  end

  assign memWrWord = {eccGen(mergedData), mergedData};

  // R10: with no load strobe the collected mask is frozen.
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!st.byteStore && !st.startLoad) |=> $stable(validMask));

  // R2: loading bytes never moves to another page.
  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st.byteStore && !st.startLoad) |=> $stable(pageNum));
endmodule

// File: rtl/pws_control.sv
module pws_control
  import pws_pkg::*;
#(
  parameter int PROG_TICKS = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       byteValid,
  input  logic       csRise,
  input  logic       bitResidue,
  input  logic       allow,
  input  logic       anyValid,
  input  logic       wordHasValid,
  input  logic       lastWord,
  output pwsStrobe_t st,
  output logic       busy,
  output logic       memRd,
  output logic       memWe,
  output logic       welClr
);
  localparam int CNT_W = $clog2(PROG_TICKS + 1);

  typedef enum logic [1:0] {C_IDLE, C_SCAN, C_WRITE, C_HOLD} cState_t;

  cState_t          state, nextState;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             commitOk;

  assign busy     = (state != C_IDLE);
  assign commitOk = csRise && armed && anyValid && allow && !bitResidue;

  always_comb begin
    st        = '0;
    memRd     = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    unique case (state)
      C_IDLE: begin
        if (csRise) begin
          if (commitOk) begin
            nextState    = C_SCAN;
            st.wordReset = 1'b1;
          end
        end else begin
          st.startLoad = startValid;
          st.byteStore = byteValid && armed && !startValid;
        end
      end
      C_SCAN: begin
        if (wordHasValid) begin
          memRd     = 1'b1;
          nextState = C_WRITE;
        end else if (lastWord) begin
          nextState = C_HOLD;
        end else begin
          st.wordAdvance = 1'b1;
        end
      end
      C_WRITE: begin
        memWe = 1'b1;
        if (lastWord) nextState = C_HOLD;
        else begin
          st.wordAdvance = 1'b1;
          nextState      = C_SCAN;
        end
      end
      C_HOLD: begin
        if (cnt == '0) nextState = C_IDLE;
      end
      default: nextState = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= C_IDLE;
      cnt    <= '0;
      armed  <= 1'b0;
      welClr <= 1'b0;
    end else begin
      state  <= nextState;
      welClr <= (state == C_HOLD) && (cnt == '0);
      if (state == C_IDLE) begin
        if (csRise)          armed <= 1'b0;
        else if (startValid) armed <= 1'b1;
        if (commitOk) cnt <= CNT_W'(PROG_TICKS - 1);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R3: a program cycle opens only on a qualified commit.
  p_busy_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise && allow && !bitResidue && anyValid));

  // R11: latch-clear pulse follows the end of busy.
  p_welclr_r11: assert property (@(posedge clk) disable iff (!rstN)
    welClr |-> (!busy && $past(busy)));

  // R5: the array is untouched outside a program cycle.
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memRd || memWe));
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import pws_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_BYTES = 64,
  parameter int PROG_TICKS = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              csRise,
  input  logic              bitResidue,
  input  logic              allow,
  output logic              busy,
  output logic              welClr,
  output logic              memRd,
  output logic              memWe,
  output logic [ADDR_W-3:0] memWordAddr,
  output logic [37:0]       memWrWord,
  input  logic [37:0]       memRdWord
);
  pwsStrobe_t st;
  logic anyValid, wordHasValid, lastWord;

  pws_control #(.PROG_TICKS(PROG_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .byteValid(byteValid),
    .csRise(csRise), .bitResidue(bitResidue), .allow(allow),
    .anyValid(anyValid), .wordHasValid(wordHasValid), .lastWord(lastWord),
    .st(st), .busy(busy), .memRd(memRd), .memWe(memWe), .welClr(welClr)
  );

  pws_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .startAddr(startAddr), .byteData(byteData),
    .memRdWord(memRdWord), .anyValid(anyValid), .wordHasValid(wordHasValid),
    .lastWord(lastWord), .memWordAddr(memWordAddr), .memWrWord(memWrWord)
  );

  // R5: every write is the second half of a read-modify-write.
  p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(memRd));

  // R6: the written word is the one that was read.
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $stable(memWordAddr));
endmodule

// File: tb/tb_page_prog_seq.sv
module tb_page_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int PAGE = 64;
  localparam int PROG = 60;
  localparam int WA_W = ADDR_W - 2;
  localparam int NWORDS = 1 << WA_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 0, byteValid = 0, csRise = 0, bitResidue = 0, allow = 1;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [7:0] byteData = '0;
  logic busy, welClr, memRd, memWe;
  logic [WA_W-1:0] memWordAddr;
  logic [37:0] memWrWord;
  logic [37:0] memRdWord = '0;

  int nTests = 0, nFail = 0;
  bit done = 0;

  logic [37:0] mem [NWORDS];
  logic [37:0] refMem [NWORDS];
  logic [WA_W+37:0] expQ [$];
  string expTag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_prog_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .PROG_TICKS(PROG)) dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .csRise(csRise),
    .bitResidue(bitResidue), .allow(allow), .busy(busy), .welClr(welClr),
    .memRd(memRd), .memWe(memWe), .memWordAddr(memWordAddr),
    .memWrWord(memWrWord), .memRdWord(memRdWord)
  );

  function automatic logic [5:0] tbPos(input int j);
    int n = 0;
    logic [5:0] r = '0;
    for (int p = 3; p < 64; p++)
      if ((p & (p - 1)) != 0) begin
        if (n == j) r = 6'(p);
        n++;
      end
    return r;
  endfunction

  function automatic logic [5:0] tbEcc(input logic [31:0] d);
    logic [5:0] e = '0;
    for (int j = 0; j < 32; j++) if (d[j]) e = e ^ tbPos(j);
    return e;
  endfunction

  function automatic logic [31:0] tbFix(input logic [37:0] w);
    logic [5:0] s = w[37:32] ^ tbEcc(w[31:0]);
    logic [31:0] d = w[31:0];
    for (int j = 0; j < 32; j++) if (s != 0 && tbPos(j) == s) d[j] = ~d[j];
    return d;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // array model: one-cycle read latency
  always @(posedge clk) begin
    if (memRd) memRdWord <= mem[memWordAddr];
    if (memWe) mem[memWordAddr] <= memWrWord;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) begin
        check(0, "R5 unexpected array write", {26'd0, memWordAddr, memWrWord}, 0);
      end else begin
        logic [WA_W+37:0] e;
        string t;
        e = expQ.pop_front();
        t = expTag.pop_front();
        check(memWordAddr == e[WA_W+37:38], {t, " R6 word address"},
              64'(memWordAddr), 64'(e[WA_W+37:38]));
        check(memWrWord == e[37:0], {t, " R7 R8 written word"},
              64'(memWrWord), 64'(e[37:0]));
      end
    end
  end

  // driver: builds expected writes from the byte stream
  task automatic expectWrites(input int sa, input int n, input logic [7:0] seed,
                              input string tag);
    logic [7:0] bufE [PAGE];
    bit maskE [PAGE];
    int page = sa / PAGE;
    for (int i = 0; i < PAGE; i++) begin maskE[i] = 0; bufE[i] = 0; end
    for (int i = 0; i < n; i++) begin
      int off = (sa + i) % PAGE;
      bufE[off] = seed + 8'(i * 13);
      maskE[off] = 1;
    end
    for (int w = 0; w < PAGE / 4; w++) begin
      if (maskE[4*w] | maskE[4*w+1] | maskE[4*w+2] | maskE[4*w+3]) begin
        int a = page * (PAGE / 4) + w;
        logic [31:0] d = tbFix(refMem[a]);
        for (int b = 0; b < 4; b++) if (maskE[4*w+b]) d[8*b +: 8] = bufE[4*w+b];
        refMem[a] = {tbEcc(d), d};
        expQ.push_back({WA_W'(a), tbEcc(d), d});
        expTag.push_back(tag);
      end
    end
  endtask

  task automatic sendStart(input int sa);
    @(negedge clk); startValid = 1; startAddr = ADDR_W'(sa);
    @(negedge clk); startValid = 0;
  endtask

  task automatic sendBytes(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byteValid = 1; byteData = seed + 8'(i * 13);
    end
    @(negedge clk); byteValid = 0;
  endtask

  task automatic sendCommit(input logic al, input logic res);
    @(negedge clk); csRise = 1; allow = al; bitResidue = res;
    @(negedge clk); csRise = 0; allow = 1; bitResidue = 0;
  endtask

  task automatic waitProgram(input int pre, input string tag);
    int n = pre;
    while (busy && n < 10 * PROG) begin n++; @(negedge clk); end
    check(n == PROG, {tag, " R4 busy length"}, 64'(n), 64'(PROG));
    check(welClr == 1'b1, {tag, " R11 welClr pulse"}, 64'(welClr), 1);
    @(negedge clk);
    check(welClr == 1'b0, {tag, " R11 welClr single cycle"}, 64'(welClr), 0);
    check(expQ.size() == 0, {tag, " R5 missing writes"}, 64'(expQ.size()), 0);
  endtask

  task automatic expectNoProgram(input string tag);
    int nb = 0;
    for (int k = 0; k < 8; k++) begin nb += int'(busy); @(negedge clk); end
    check(nb == 0, {tag, " R3 no program cycle"}, 64'(nb), 0);
  endtask

  task automatic doWrite(input int sa, input int n, input logic [7:0] seed,
                         input string tag);
    expectWrites(sa, n, seed, tag);
    sendStart(sa);
    sendBytes(n, seed);
    sendCommit(1, 0);
    waitProgram(0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) begin
      logic [31:0] d = 32'(i) * 32'h0101_0101 ^ 32'h5A3C_9600;
      mem[i] = {tbEcc(d), d};
      refMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(busy == 0 && welClr == 0, "R1 busy/welClr after reset",
          64'({busy, welClr}), 0);
    check(memRd == 0 && memWe == 0, "R1 no array access after reset",
          64'({memRd, memWe}), 0);

    // single byte, lane 1 of word 1, page 0
    doWrite(5, 1, 8'hA5, "R7 single byte");

    // wrap inside page 3: offsets 62,63,0,1,2
    doWrite(3 * PAGE + 62, 5, 8'h30, "R2 wrap");

    // 66 bytes into page 2: offsets 0,1 overwritten
    doWrite(2 * PAGE, 66, 8'h11, "R2 overwrite");

    // empty transaction
    sendStart(PAGE + 8);
    sendCommit(1, 0);
    expectNoProgram("R3 zero bytes");
    // refused by protection
    sendStart(PAGE + 8);
    sendBytes(3, 8'h77);
    sendCommit(0, 0);
    expectNoProgram("R3 allow low");
    // partial byte at commit
    sendStart(PAGE + 8);
    sendBytes(3, 8'h78);
    sendCommit(1, 1);
    expectNoProgram("R3 bit residue");

    // strobes during busy are ignored
    begin
      int nb = 0;
      expectWrites(4 * PAGE + 20, 2, 8'h90, "R10 busy noise");
      sendStart(4 * PAGE + 20);
      sendBytes(2, 8'h90);
      sendCommit(1, 0);
      nb += int'(busy); startValid = 1; startAddr = ADDR_W'(5 * PAGE);
      @(negedge clk);
      nb += int'(busy); startValid = 0; byteValid = 1; byteData = 8'hEE;
      @(negedge clk);
      nb += int'(busy); byteValid = 0; csRise = 1;
      @(negedge clk);
      csRise = 0;
      waitProgram(nb, "R10 busy noise");
    end
    // commit with no fresh start after the noise: nothing happens
    sendBytes(2, 8'h44);
    sendCommit(1, 0);
    expectNoProgram("R10 no arm from busy strobes");

    // single-bit error in stored data, write to another lane
    begin
      int a = 6 * (PAGE / 4) + 2;
      mem[a][17] = ~mem[a][17];
      refMem[a] = mem[a];
      doWrite(6 * PAGE + 8, 1, 8'h3C, "R9 corrected merge");
      check(mem[a][17] == refMem[a][17], "R9 flipped bit repaired",
            64'(mem[a][17]), 64'(refMem[a][17]));
    end

    // following write after all of that lands normally
    doWrite(7 * PAGE + 63, 1, 8'hC3, "R6 last word of page");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule